// File: doc/BRIEF.md
# Paged Management Memory Serial Target

This block is a two-wire serial (I2C-style) target that exposes a module management memory map to a host. It oversamples the clock and data lines with the system clock, drives the data line only by pulling it low, and takes part in bus traffic only while its active-low select input is held low. Because of that select input, several modules can share one two-wire bus.

The byte address space is split in two halves. Addresses 0 to 127 form one fixed lower region that is always reachable. Addresses 128 to 255 are a window onto one of several upper pages, picked by a page register kept inside the block at lower address 127. One upper page is free user storage. The block does not hold the memory itself. It presents a byte address and a page number, and it takes the read byte back in the same cycle. Writes to the user page leave through a one-cycle write port. Reads of the interrupt-flag bytes are collected during a transaction and reported as a single clear strobe, with a byte mask, once the stop condition has been seen.

Top module: `mgmt_mem_target`

## Requirements
- R1: While `modSelN` is high the block never pulls SDA low, acknowledges nothing and changes no state. A write attempted while deselected leaves the page register unchanged.
- R2: Only the 7-bit device address 50h is acknowledged (A0h for a write, A1h for a read, in 8-bit form). Any other address is answered with SDA left high, and the rest of that transaction is ignored.
- R3: In a write transaction the first data byte loads the byte pointer. Each further byte is stored at the pointer, after which the pointer advances. Every data byte is acknowledged.
- R4: Sequential reads return consecutive bytes. The pointer wraps within its own 128-byte half: after 127 comes 0, and after 255 comes 128.
- R5: Lower address 127 is the page register. It reads back the last value written to it, and that value appears on `memPage` and selects the page used by later accesses to addresses 128 to 255. After reset it is 0.
- R6: A write to addresses 128 to 255 while the page register holds 2 produces one `memWe` pulse, with `memWrAddr` equal to the address minus 128 and `memWrData` equal to the byte. That byte is then read back.
- R7: A write to any other location (lower addresses 0 to 126, or upper pages other than 2) is acknowledged, but it raises no `memWe` and changes nothing that a later read returns.
- R8: Flag bytes sit at lower addresses 3, 4 and 5 (mask bits 0, 1 and 2). When a read transaction has read any of them, `flagClr` pulses for exactly one cycle after the stop condition, with `flagClrMask` naming exactly those bytes. No pulse comes before the stop, and no pulse comes when no flag byte was read.
- R9: Upper reads with the page register at 4 or higher return 00h.
- R10: When the host does not acknowledge a read byte, the read ends and the block releases SDA.
- R11: After reset `sdaOe`, `memWe` and `flagClr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line as sensed |
| sdaIn | input | 1 | Serial data line as sensed |
| modSelN | input | 1 | Active-low select; high means ignore the bus |
| sdaOe | output | 1 | High pulls the data line low |
| memAddr | output | 8 | Byte address of the current read |
| memPage | output | 8 | Current page register value |
| memRdData | input | 8 | Memory byte for memAddr/memPage, same cycle |
| memWe | output | 1 | One-cycle write strobe for user-page storage |
| memWrAddr | output | 7 | Offset within the user page |
| memWrData | output | 8 | Byte to store |
| flagClr | output | 1 | One-cycle clear strobe after a flag read |
| flagClrMask | output | 3 | Flag bytes to clear, bit i for address 3+i |

## Verification
The one load strobe that fetches a read byte also advances the pointer. When the pointer sits at 127, this strobe returns the page register instead of memory and wraps the pointer to 0 in the same cycle. A directed sequential read starting at 126 provokes this, and the three returned bytes are judged against the memory byte at 126, the page value and the memory byte at 0. A second case arises when a write burst crosses address 127: the new page value and the wrap happen together. A readback then judges whether the next upper access used the new page.

// File: rtl/mgmt_target_pkg.sv
`timescale 1ns/1ps
package mgmt_target_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_RX,
    ST_TX,
    ST_MACK
  } state_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic shiftIn;    // sample one received bit
    logic loadTx;     // fetch next read byte, advance pointer
    logic shiftTx;    // move to next transmit bit
    logic commit;     // a received data byte is complete
    logic firstByte;  // the committed byte is the pointer byte
    logic stopSeen;   // stop condition while selected
    logic abort;      // deselected
  } ctl_t;

endpackage

// File: rtl/mgmt_in_sync.sv
`timescale 1ns/1ps
module mgmt_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic modSelN,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet,
  output logic sdaBit,
  output logic selected
);
  localparam int W = 3;

  logic [STAGES-1:0][W-1:0] chain;
  logic [W-1:0] synced;
  logic [1:0]   prevLines;

  // idle bus and deselected at reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain     <= '1;
      prevLines <= 2'b11;
    end else begin
      chain     <= {chain[STAGES-2:0], {modSelN, sdaIn, sclIn}};
      prevLines <= synced[1:0];
    end
  end

  assign synced   = chain[STAGES-1];
  assign sclRise  = synced[0] & ~prevLines[0];
  assign sclFall  = ~synced[0] & prevLines[0];
  assign startDet = synced[0] & prevLines[0] & prevLines[1] & ~synced[1];
  assign stopDet  = synced[0] & prevLines[0] & ~prevLines[1] & synced[1];
  assign sdaBit   = synced[1];
  assign selected = ~synced[2];
endmodule

// File: rtl/mgmt_ctrl.sv
`timescale 1ns/1ps
module mgmt_ctrl
  import mgmt_target_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic       sdaBit,
  input  logic       selected,
  input  logic [7:0] shByte,
  input  logic       txBit,
  output ctl_t       ctl,
  output logic       sdaOe
);
  localparam logic [3:0] LAST_BIT = 4'd8;

  state_t     state;
  logic [3:0] bitCnt;
  logic       addrAck;
  logic       rwBit;
  logic       firstByte;
  logic       masterAck;
  logic       live;
  logic       atEight;

  assign live    = selected && !startDet && !stopDet;
  assign atEight = (bitCnt == LAST_BIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      addrAck   <= 1'b0;
      rwBit     <= 1'b0;
      firstByte <= 1'b0;
      masterAck <= 1'b0;
    end else if (!selected) begin
      state <= ST_IDLE;
    end else if (startDet) begin
      state  <= ST_ADDR;
      bitCnt <= '0;
    end else if (stopDet) begin
      state <= ST_IDLE;
    end else begin
      if (sclRise && (state inside {ST_ADDR, ST_RX, ST_TX}))
        bitCnt <= bitCnt + 4'd1;
      case (state)
        ST_ADDR: if (sclFall && atEight) begin
          bitCnt <= '0;
          if (shByte[7:1] == DEV_ADDR) begin
            state     <= ST_ACK;
            addrAck   <= 1'b1;
            rwBit     <= shByte[0];
            firstByte <= 1'b1;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_ACK: if (sclFall) begin
          addrAck <= 1'b0;
          state   <= (addrAck && rwBit) ? ST_TX : ST_RX;
        end
        ST_RX: if (sclFall && atEight) begin
          state     <= ST_ACK;
          bitCnt    <= '0;
          firstByte <= 1'b0;
        end
        ST_TX: if (sclFall && atEight) begin
          state  <= ST_MACK;
          bitCnt <= '0;
        end
        ST_MACK: begin
          if (sclRise) masterAck <= !sdaBit;
          if (sclFall) state <= masterAck ? ST_TX : ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    ctl.shiftIn   = live && sclRise && (state == ST_ADDR || state == ST_RX);
    ctl.loadTx    = live && sclFall &&
                    ((state == ST_ACK && addrAck && rwBit) ||
                     (state == ST_MACK && masterAck));
    ctl.shiftTx   = live && sclFall && (state == ST_TX) && !atEight;
    ctl.commit    = live && sclFall && (state == ST_RX) && atEight;
    ctl.firstByte = firstByte;
    ctl.stopSeen  = selected && stopDet;
    ctl.abort     = !selected;
  end

  assign sdaOe = selected && (state == ST_ACK || (state == ST_TX && !txBit));
endmodule

// File: rtl/mgmt_dp.sv
`timescale 1ns/1ps
module mgmt_dp
  import mgmt_target_pkg::*;
#(
  parameter int NUM_PAGES = 4,
  parameter int USER_PAGE = 2,
  parameter int FLAG_BASE = 3,
  parameter int NUM_FLAG  = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctl_t                ctl,
  input  logic                sdaBit,
  input  logic [7:0]          memRdData,
  output logic [7:0]          shByte,
  output logic                txBit,
  output logic [7:0]          memAddr,
  output logic [7:0]          memPage,
  output logic                memWe,
  output logic [6:0]          memWrAddr,
  output logic [7:0]          memWrData,
  output logic                flagClr,
  output logic [NUM_FLAG-1:0] flagClrMask
);
  localparam logic [7:0] PAGE_REG_ADDR = 8'h7F;
  localparam logic [7:0] PAGE_LIMIT    = 8'(NUM_PAGES);
  localparam logic [7:0] USER_PG       = 8'(USER_PAGE);

  logic [7:0]          shReg;
  logic [7:0]          ptr;
  logic [7:0]          pageReg;
  logic [7:0]          rdByte;
  logic [7:0]          nextPtr;
  logic [NUM_FLAG-1:0] flagMask;
  logic [NUM_FLAG-1:0] flagHit;

  // one comparator per flag byte
  for (genvar i = 0; i < NUM_FLAG; i++) begin : g_flag
    localparam logic [7:0] FADDR = 8'(FLAG_BASE + i);
    assign flagHit[i] = (ptr == FADDR);
  end

  assign nextPtr = {ptr[7], ptr[6:0] + 7'd1};

  always_comb begin
    if (ptr == PAGE_REG_ADDR)                 rdByte = pageReg;
    else if (ptr[7] && pageReg >= PAGE_LIMIT) rdByte = 8'h00;
    else                                      rdByte = memRdData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg       <= '0;
      ptr         <= '0;
      pageReg     <= '0;
      memWe       <= 1'b0;
      memWrAddr   <= '0;
      memWrData   <= '0;
      flagMask    <= '0;
      flagClr     <= 1'b0;
      flagClrMask <= '0;
    end else begin
      memWe   <= 1'b0;
      flagClr <= 1'b0;
      if (ctl.shiftIn) shReg <= {shReg[6:0], sdaBit};
      if (ctl.shiftTx) shReg <= {shReg[6:0], 1'b0};
      if (ctl.loadTx) begin
        shReg    <= rdByte;
        ptr      <= nextPtr;
        flagMask <= flagMask | flagHit;
      end
      if (ctl.commit) begin
        if (ctl.firstByte) begin
          ptr <= shReg;
        end else begin
          ptr <= nextPtr;
          if (ptr == PAGE_REG_ADDR) begin
            pageReg <= shReg;
          end else if (ptr[7] && pageReg == USER_PG) begin
            memWe     <= 1'b1;
            memWrAddr <= ptr[6:0];
            memWrData <= shReg;
          end
        end
      end
      if (ctl.stopSeen) begin
        if (|flagMask) begin
          flagClr     <= 1'b1;
          flagClrMask <= flagMask;
        end
        flagMask <= '0;
      end
      if (ctl.abort) flagMask <= '0;
    end
  end

  assign shByte  = shReg;
  assign txBit   = shReg[7];
  assign memAddr = ptr;
  assign memPage = pageReg;
endmodule

// File: rtl/mgmt_mem_target.sv
`timescale 1ns/1ps
module mgmt_mem_target
  import mgmt_target_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         NUM_PAGES   = 4,
  parameter int         USER_PAGE   = 2,
  parameter int         FLAG_BASE   = 3,
  parameter int         NUM_FLAG    = 3,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclIn,
  input  logic                sdaIn,
  input  logic                modSelN,
  output logic                sdaOe,
  output logic [7:0]          memAddr,
  output logic [7:0]          memPage,
  input  logic [7:0]          memRdData,
  output logic                memWe,
  output logic [6:0]          memWrAddr,
  output logic [7:0]          memWrData,
  output logic                flagClr,
  output logic [NUM_FLAG-1:0] flagClrMask
);
  logic sclRise, sclFall, startDet, stopDet, sdaBit, selected, txBit;
  logic [7:0] shByte;
  ctl_t ctl;

  mgmt_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk, .rstN, .sclIn, .sdaIn, .modSelN,
    .sclRise, .sclFall, .startDet, .stopDet, .sdaBit, .selected
  );

  mgmt_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk, .rstN, .sclRise, .sclFall, .startDet, .stopDet, .sdaBit,
    .selected, .shByte, .txBit, .ctl, .sdaOe
  );

  mgmt_dp #(
    .NUM_PAGES(NUM_PAGES), .USER_PAGE(USER_PAGE),
    .FLAG_BASE(FLAG_BASE), .NUM_FLAG(NUM_FLAG)
  ) u_dp (
    .clk, .rstN, .ctl, .sdaBit, .memRdData, .shByte, .txBit,
    .memAddr, .memPage, .memWe, .memWrAddr, .memWrData,
    .flagClr, .flagClrMask
  );
endmodule

// File: rtl/mgmt_mem_target_chk.sv
`timescale 1ns/1ps
module mgmt_mem_target_chk #(
  parameter int USER_PAGE = 2,
  parameter int NUM_FLAG  = 3
) (
  input logic                clk,
  input logic                rstN,
  input logic                modSelN,
  input logic                sdaOe,
  input logic                memWe,
  input logic [7:0]          memPage,
  input logic                flagClr,
  input logic [NUM_FLAG-1:0] flagClrMask
);
  localparam logic [7:0] USER_PG = 8'(USER_PAGE);

  // R1: a settled deselect keeps the line released
  p_quiet_sda_r1: assert property (@(posedge clk) disable iff (!rstN)
    (modSelN && $past(modSelN) && $past(modSelN, 2) && $past(modSelN, 3)) |-> !sdaOe);

  // R1: a settled deselect issues no storage write
  p_quiet_we_r1: assert property (@(posedge clk) disable iff (!rstN)
    (modSelN && $past(modSelN) && $past(modSelN, 2) && $past(modSelN, 3)) |-> !memWe);

  // R6: writes leave only while the user page is selected
  p_user_only_r6: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memPage == USER_PG));

  // R6: write strobe lasts one cycle
  p_we_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> !memWe);

  // R8: clear strobe lasts one cycle
  p_clr_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    flagClr |=> !flagClr);

  // R8: a clear always names at least one flag byte
  p_clr_mask_r8: assert property (@(posedge clk) disable iff (!rstN)
    flagClr |-> (flagClrMask != '0));
endmodule

bind mgmt_mem_target mgmt_mem_target_chk #(
  .USER_PAGE(USER_PAGE), .NUM_FLAG(NUM_FLAG)
) u_chk (.*);

// File: tb/mgmt_mem_target_tb.sv
`timescale 1ns/1ps
module mgmt_mem_target_tb;
  localparam int FLAG_BASE = 3;
  localparam int NUM_FLAG  = 3;
  localparam int HALF      = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic sdaDrv = 1'b1;
  logic modSelN = 1'b0;
  logic sdaLine;
  logic sdaOe, memWe, flagClr;
  logic [7:0] memAddr, memPage, memRdData, memWrData;
  logic [6:0] memWrAddr;
  logic [NUM_FLAG-1:0] flagClrMask;

  int checks = 0;
  int failures = 0;
  int clrCount = 0;
  int weCount = 0;
  logic [NUM_FLAG-1:0] lastMask = '0;
  bit done = 0;

  logic [7:0] userMem [128];
  logic [7:0] mUser [128];
  logic [7:0] mPtr = 8'h00;
  logic [7:0] mPage = 8'h00;
  logic [7:0] wbuf [4];

  always #HALF clk = ~clk;
  assign sdaLine = sdaDrv & ~sdaOe;

  mgmt_mem_target u_dut (
    .clk, .rstN, .sclIn(scl), .sdaIn(sdaLine), .modSelN, .sdaOe,
    .memAddr, .memPage, .memRdData, .memWe, .memWrAddr, .memWrData,
    .flagClr, .flagClrMask
  );

  function automatic logic [7:0] romByte(input logic [7:0] pg, input logic [7:0] a);
    return (a * 8'd7) ^ (pg * 8'd29) ^ 8'h5A;
  endfunction

  always_comb begin
    if (!memAddr[7])        memRdData = romByte(8'hFF, memAddr);
    else if (memPage == 8'd2) memRdData = userMem[memAddr[6:0]];
    else                    memRdData = romByte(memPage, memAddr);
  end

  always @(posedge clk) if (memWe) userMem[memWrAddr] <= memWrData;

  always @(negedge clk) begin
    if (flagClr) begin clrCount++; lastMask = flagClrMask; end
    if (memWe) weCount++;
  end

  function automatic logic [7:0] expRead(input logic [7:0] a);
    if (a == 8'd127) return mPage;
    if (!a[7]) return romByte(8'hFF, a);
    if (mPage >= 8'd4) return 8'h00;
    if (mPage == 8'd2) return mUser[a[6:0]];
    return romByte(mPage, a);
  endfunction

  function automatic logic [7:0] incPtr(input logic [7:0] a);
    return {a[7], a[6:0] + 7'd1};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setBit(input logic b);
    waitClk(5); sdaDrv = b; waitClk(5);
    scl = 1'b1; waitClk(10); scl = 1'b0;
  endtask

  task automatic readBit(output logic v);
    waitClk(5); sdaDrv = 1'b1; waitClk(5);
    scl = 1'b1; waitClk(5); v = sdaLine; waitClk(5); scl = 1'b0;
  endtask

  task automatic busStart();
    waitClk(5); sdaDrv = 1'b1; waitClk(5);
    scl = 1'b1; waitClk(10); sdaDrv = 1'b0; waitClk(10); scl = 1'b0;
  endtask

  task automatic busStop();
    waitClk(5); sdaDrv = 1'b0; waitClk(5);
    scl = 1'b1; waitClk(10); sdaDrv = 1'b1; waitClk(10);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    logic v;
    for (int i = 7; i >= 0; i--) setBit(b[i]);
    readBit(v);
    ack = !v;
  endtask

  task automatic recvByte(input logic nack, output logic [7:0] b);
    logic v;
    for (int i = 7; i >= 0; i--) begin readBit(v); b[i] = v; end
    setBit(nack);
  endtask

  task automatic modelWrite(input logic [7:0] d, inout int weAdd);
    if (mPtr == 8'd127) mPage = d;
    else if (mPtr[7] && mPage == 8'd2) begin mUser[mPtr[6:0]] = d; weAdd++; end
    mPtr = incPtr(mPtr);
  endtask

  // R3 R6 R7: pointer byte, then n data bytes
  task automatic doWrite(input logic [7:0] a, input int n);
    bit ack;
    int weBefore;
    int weAdd;
    weAdd = 0;
    weBefore = weCount;
    busStart();
    sendByte(8'hA0, ack); chk(ack, "R2 write address ack", ack, 1);
    sendByte(a, ack);     chk(ack, "R3 pointer byte ack", ack, 1);
    mPtr = a;
    for (int i = 0; i < n; i++) begin
      sendByte(wbuf[i], ack);
      chk(ack, "R7 data byte ack", ack, 1);
      modelWrite(wbuf[i], weAdd);
    end
    busStop();
    waitClk(4);
    chk(weCount == weBefore + weAdd, "R6 write strobe count", weCount - weBefore, weAdd);
  endtask

  // R4 R8 R10: set pointer, repeated start, read n bytes
  task automatic doRead(input logic [7:0] a, input int n, input string tag);
    bit ack;
    logic [7:0] b;
    logic [7:0] e;
    logic [NUM_FLAG-1:0] expMask;
    int clrBefore;
    expMask = '0;
    clrBefore = clrCount;
    busStart();
    sendByte(8'hA0, ack); chk(ack, "R2 write address ack", ack, 1);
    sendByte(a, ack);     chk(ack, "R3 pointer byte ack", ack, 1);
    mPtr = a;
    busStart();
    sendByte(8'hA1, ack); chk(ack, "R2 read address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recvByte(i == n - 1, b);
      e = expRead(mPtr);
      if (mPtr >= 8'(FLAG_BASE) && mPtr < 8'(FLAG_BASE + NUM_FLAG))
        expMask[mPtr - 8'(FLAG_BASE)] = 1'b1;
      chk(b == e, tag, b, e);
      mPtr = incPtr(mPtr);
    end
    waitClk(8);
    chk(sdaOe == 1'b0, "R10 released after host nack", sdaOe, 0);
    chk(clrCount == clrBefore, "R8 no clear before stop", clrCount - clrBefore, 0);
    busStop();
    waitClk(4);
    if (expMask != '0) begin
      chk(clrCount == clrBefore + 1, "R8 one clear after stop", clrCount - clrBefore, 1);
      chk(lastMask == expMask, "R8 clear mask", lastMask, expMask);
    end else begin
      chk(clrCount == clrBefore, "R8 no clear without flag read", clrCount - clrBefore, 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit ack;
    int weBefore;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 128; i++) begin
      userMem[i] = 8'(i) ^ 8'h3C;
      mUser[i]   = 8'(i) ^ 8'h3C;
    end
    waitClk(5);
    // R11 reset state
    chk(sdaOe == 1'b0, "R11 sdaOe after reset", sdaOe, 0);
    chk(memWe == 1'b0, "R11 memWe after reset", memWe, 0);
    chk(flagClr == 1'b0, "R11 flagClr after reset", flagClr, 0);
    rstN = 1'b1;
    waitClk(10);
    chk(memPage == 8'h00, "R5 page after reset", memPage, 0);

    // R2 foreign address
    busStart();
    sendByte(8'hA4, ack);
    chk(!ack, "R2 foreign address not acked", ack, 0);
    busStop();

    // R1 deselected traffic is ignored
    modSelN = 1'b1;
    waitClk(6);
    weBefore = weCount;
    busStart();
    sendByte(8'hA0, ack); chk(!ack, "R1 no ack while deselected", ack, 0);
    sendByte(8'd127, ack);
    sendByte(8'h05, ack); chk(!ack, "R1 data not acked while deselected", ack, 0);
    busStop();
    modSelN = 1'b0;
    waitClk(6);
    chk(memPage == 8'h00, "R1 page unchanged", memPage, 0);
    doRead(8'd127, 1, "R1 page readback");

    // R5 page select, R6 user writes
    wbuf[0] = 8'h02;
    doWrite(8'd127, 1);
    chk(memPage == 8'h02, "R5 page port", memPage, 2);
    wbuf[0] = 8'hA5; wbuf[1] = 8'h5A; wbuf[2] = 8'hC3;
    doWrite(8'h80, 3);
    chk(userMem[0] == 8'hA5, "R6 write data/offset", userMem[0], 8'hA5);
    doRead(8'h80, 3, "R6 user readback");

    // R7 read-only lower byte
    wbuf[0] = 8'hEE;
    doWrite(8'd10, 1);
    doRead(8'd10, 1, "R7 read-only unchanged");

    // R4 wrap in both halves, page byte fetched mid-burst
    doRead(8'd126, 3, "R4 lower wrap via page byte");
    doRead(8'd255, 2, "R4 upper wrap");

    // R5/R4 write burst across 127 changes page then wraps
    wbuf[0] = 8'h01; wbuf[1] = 8'h77;
    doWrite(8'd127, 2);
    chk(memPage == 8'h01, "R5 page after crossing burst", memPage, 1);
    doRead(8'h90, 2, "R5 new page used");

    // R9 absent page
    wbuf[0] = 8'h06;
    doWrite(8'd127, 1);
    doRead(8'hC0, 2, "R9 absent page reads zero");
    wbuf[0] = 8'h11;
    doWrite(8'hC0, 1);
    doRead(8'hC0, 1, "R9 write to absent page ignored");

    // R8 flag bytes
    doRead(8'd2, 5, "R8 flag window read");
    doRead(8'd4, 1, "R8 single flag read");

    // random mix
    for (int it = 0; it < 40; it++) begin
      int n;
      logic [7:0] a;
      n = 1 + int'($urandom % 4);
      a = ($urandom % 2) ? 8'($urandom % 128) : 8'(128 + $urandom % 128);
      case ($urandom % 4)
        0: begin wbuf[0] = 8'($urandom % 6); doWrite(8'd127, 1); end
        1: begin
          for (int k = 0; k < 4; k++) wbuf[k] = 8'($urandom);
          doWrite(a, n);
        end
        default: doRead(a, n, "R4 random read");
      endcase
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule